// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Preset

This block is one synchronous, reversible counter stage of `W` bits. A parameter picks plain binary counting, which wraps through all `2**W` values, or decade counting in 8-4-2-1 code, which wraps between 9 and 0. The active-low count enable gates counting. A direction input selects up (low) or down (high). All state bits change together on the rising clock edge.

An active-low preset copies the preset value onto the count output at once, whatever the clock is doing, and overrides both counting and reset. Two outputs support chaining. The terminal flag goes high while the count sits at the point where the next step in the current direction wraps. The active-low chain output pulses for the low phase of the clock while the stage is enabled and at that point.

Stages are chained in one of two ways. With a shared clock, the chain output drives the next stage's enable. With a shared enable, the chain output drives the next stage's clock instead.

Top module: `updn_cascade_cnt`

## Requirements
- R1: With `preset_n` high, a rising clock edge seen while `rst_n` is low sets `count` to 0.
- R2: With `dir_down` low and `cnt_en_n` low, each rising edge adds one. The step after the top value is 0. The top value is `2**W-1` in binary mode and 9 in decade mode.
- R3: With `dir_down` high and `cnt_en_n` low, each rising edge subtracts one. The step after 0 is the top value.
- R4: While `cnt_en_n` is high, a rising edge leaves `count` unchanged.
- R5: While `preset_n` is low, `count` equals `preset_val` without waiting for a clock edge. When `preset_n` goes high again, counting resumes from that value. Preset takes priority over reset and counting.
- R6: `term_flag` is high exactly when the count equals the top value with `dir_down` low, or equals 0 with `dir_down` high. The level of `cnt_en_n` does not affect it.
- R7: `chain_n` is low exactly while `cnt_en_n` is low, `term_flag` is high and `clk` is low.
- R8: In decade mode, a count from 10 to 15 never raises `term_flag`. The next enabled edge takes it to 0 when counting up and to 9 when counting down.
- R9: Two stages sharing a clock, with the low stage's `chain_n` on the high stage's `cnt_en_n`, count 0..255 (binary) or 0..99 (decade) in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| preset_n | input | 1 | Active-low asynchronous parallel preset |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| preset_val | input | W | Value forced by the preset |
| count | output | W | Current count |
| term_flag | output | 1 | High at the wrap point for the current direction |
| chain_n | output | 1 | Active-low cascade pulse during the clock low phase |

## Verification
Two behaviours can fall in the same cycle: a preset held across a rising edge while the stage is enabled, and a count step at that same edge. The bench drives exactly this case. It lowers the preset mid-cycle with the enable low and keeps it low across an edge. It then checks that `count` shows the preset value before the edge and that it still holds that value after the edge, with no extra step. The same collision happens in the upper stage of each chained pair, because the lower stage's chain pulse can enable the upper stage while the preset is active. The expected value of the whole pair is judged from a model of an 8-bit or two-digit number.

// File: rtl/updn_pkg.sv
// Package: shared mode type and derived constants for the up/down counter.
// Assumes: decade mode is used with W >= 4.
package updn_pkg;

    typedef enum logic {
        CNT_BINARY = 1'b0,
        CNT_DECADE = 1'b1
    } cnt_mode_e;

    // Highest legal count for a given width and mode.
    function automatic int top_of(input int w, input cnt_mode_e m);
        return (m == CNT_DECADE) ? 9 : ((1 << w) - 1);
    endfunction

endpackage

// File: rtl/updn_step.sv
// Module: combinational next-count logic for one step in the chosen direction.
// Assumes: cur may hold an illegal decade value after a preset; such values
// are sent to 0 going up and to the top value going down.
module updn_step #(
    parameter int                 W    = 4,
    parameter updn_pkg::cnt_mode_e MODE = updn_pkg::CNT_BINARY
) (
    input  logic [W-1:0] cur,
    input  logic         dir_down,
    output logic [W-1:0] nxt
);
    localparam int          TOP_I = updn_pkg::top_of(W, MODE);
    localparam logic [W-1:0] TOP  = TOP_I[W-1:0];

    generate
        if (MODE == updn_pkg::CNT_BINARY) begin : g_bin
            // Purpose: full-width increment or decrement, wrapping naturally.
            always_comb begin
                if (dir_down) nxt = cur - 1'b1;
                else          nxt = cur + 1'b1;
            end
        end else begin : g_dec
            // Purpose: decade step with wrap and illegal-value recovery.
            always_comb begin
                if (dir_down) begin
                    if (cur == '0 || cur > TOP) nxt = TOP;
                    else                        nxt = cur - 1'b1;
                end else begin
                    if (cur >= TOP) nxt = '0;
                    else            nxt = cur + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/updn_term.sv
// Module: terminal-count decode and clock-gated cascade pulse.
// Assumes: clk is the same clock that updates cur; the pulse occupies the
// low phase of that clock only.
module updn_term #(
    parameter int                 W    = 4,
    parameter updn_pkg::cnt_mode_e MODE = updn_pkg::CNT_BINARY
) (
    input  logic         clk,
    input  logic [W-1:0] cur,
    input  logic         dir_down,
    input  logic         cnt_en_n,
    output logic         term_flag,
    output logic         chain_n
);
    localparam int          TOP_I = updn_pkg::top_of(W, MODE);
    localparam logic [W-1:0] TOP  = TOP_I[W-1:0];

    // Purpose: flag the wrap point for the present direction, enable ignored.
    always_comb begin
        if (dir_down) term_flag = (cur == '0);
        else          term_flag = (cur == TOP);
    end

    // Purpose: low pulse while enabled, at the wrap point, and clock low.
    always_comb begin
        chain_n = ~(~cnt_en_n & term_flag & ~clk);
    end
endmodule

// File: rtl/updn_state.sv
// Module: count register with asynchronous parallel preset and synchronous reset.
// Assumes: preset_val is stable from the falling edge of preset_n until it
// rises; while preset_n is low the output follows preset_val directly.
module updn_state #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_n,
    input  logic         cnt_en_n,
    input  logic [W-1:0] preset_val,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_r;

    // Purpose: preset overrides all; else reset; else step when enabled.
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)      cnt_r <= preset_val;
        else if (!rst_n)    cnt_r <= '0;
        else if (!cnt_en_n) cnt_r <= nxt;
    end

    // Purpose: show the preset value at once while the preset is held.
    always_comb begin
        count = preset_n ? cnt_r : preset_val;
    end
endmodule

// File: rtl/updn_cascade_cnt.sv
// Module: one cascadable up/down counter stage with preset, binary or decade.
// Assumes: direction and enable change only while clk is high; a following
// stage samples chain_n after some propagation delay past the clock edge.
module updn_cascade_cnt #(
    parameter int                 W    = 4,
    parameter updn_pkg::cnt_mode_e MODE = updn_pkg::CNT_BINARY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_n,
    input  logic         cnt_en_n,
    input  logic         dir_down,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] count,
    output logic         term_flag,
    output logic         chain_n
);
    logic [W-1:0] nxt;

    updn_step #(.W(W), .MODE(MODE)) u_step (
        .cur      (count),
        .dir_down (dir_down),
        .nxt      (nxt)
    );

    updn_state #(.W(W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_n   (preset_n),
        .cnt_en_n   (cnt_en_n),
        .preset_val (preset_val),
        .nxt        (nxt),
        .count      (count)
    );

    updn_term #(.W(W), .MODE(MODE)) u_term (
        .clk       (clk),
        .cur       (count),
        .dir_down  (dir_down),
        .cnt_en_n  (cnt_en_n),
        .term_flag (term_flag),
        .chain_n   (chain_n)
    );
endmodule

// File: rtl/updn_cascade_cnt_chk.sv
// Module: property checker for one counter stage, bound to the top module.
// Assumes: sampled at the rising clock edge; presets between edges are
// tracked so count checks skip cycles a preset may have touched.
module updn_cascade_cnt_chk #(
    parameter int                 W    = 4,
    parameter updn_pkg::cnt_mode_e MODE = updn_pkg::CNT_BINARY
) (
    input logic         clk,
    input logic         rst_n,
    input logic         preset_n,
    input logic         cnt_en_n,
    input logic         dir_down,
    input logic [W-1:0] preset_val,
    input logic [W-1:0] count,
    input logic         term_flag,
    input logic         chain_n
);
    localparam int          TOP_I = updn_pkg::top_of(W, MODE);
    localparam logic [W-1:0] TOP  = TOP_I[W-1:0];

    logic pre_seen;

    // Purpose: remember any preset since the previous rising edge.
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) pre_seen <= 1'b1;
        else           pre_seen <= 1'b0;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        (!rst_n && preset_n) |=> (pre_seen || !preset_n || count == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !cnt_en_n && !dir_down && count <= TOP)
        |=> (pre_seen || count == (($past(count) == TOP) ? '0 : $past(count) + 1'b1)));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !cnt_en_n && dir_down && count <= TOP)
        |=> (pre_seen || count == (($past(count) == '0) ? TOP : $past(count) - 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && cnt_en_n) |=> (pre_seen || $stable(count)));

    // R5
    preset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |-> (count == preset_val));

    // R6
    flag_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_flag |-> (count == '0 || count == TOP));

    // R6
    flag_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && count == TOP) |-> term_flag);

    // R7
    chain_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_n |-> (term_flag && !cnt_en_n));

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count > TOP) |-> !term_flag);

    // R8
    illegal_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !cnt_en_n && count > TOP) |=> (pre_seen || count <= TOP));
endmodule

bind updn_cascade_cnt updn_cascade_cnt_chk #(.W(W), .MODE(MODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_n   (preset_n),
    .cnt_en_n   (cnt_en_n),
    .dir_down   (dir_down),
    .preset_val (preset_val),
    .count      (count),
    .term_flag  (term_flag),
    .chain_n    (chain_n)
);

// File: tb/test_updn_cascade_cnt.sv
`timescale 1ns/1ps
// Bench: two chained pairs (binary and decade), each pair sharing the clock,
// low stage's chain output feeding the high stage's enable after 1 ns.
module test_updn_cascade_cnt;
    logic       clk = 1'b0;
    logic       rst_n, preset_n, cnt_en_n, dir_down;
    logic [7:0] bdata;
    logic [3:0] dlo_d, dhi_d;

    logic [3:0] bq_lo, bq_hi, dq_lo, dq_hi;
    logic       b_mm_lo, b_rco_lo, b_mm_hi, b_rco_hi, b_en_hi;
    logic       d_mm_lo, d_rco_lo, d_mm_hi, d_rco_hi, d_en_hi;

    int  n_chk = 0;
    int  n_bad = 0;
    int  exp_b = 0;
    int  exp_d = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    assign #1 b_en_hi = b_rco_lo;
    assign #1 d_en_hi = d_rco_lo;

    updn_cascade_cnt #(.W(4), .MODE(updn_pkg::CNT_BINARY)) i_updn_cascade_cnt (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .cnt_en_n(cnt_en_n),
        .dir_down(dir_down), .preset_val(bdata[3:0]), .count(bq_lo),
        .term_flag(b_mm_lo), .chain_n(b_rco_lo));
    updn_cascade_cnt #(.W(4), .MODE(updn_pkg::CNT_BINARY)) i_updn_cascade_cnt_bh (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .cnt_en_n(b_en_hi),
        .dir_down(dir_down), .preset_val(bdata[7:4]), .count(bq_hi),
        .term_flag(b_mm_hi), .chain_n(b_rco_hi));
    updn_cascade_cnt #(.W(4), .MODE(updn_pkg::CNT_DECADE)) i_updn_cascade_cnt_dl (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .cnt_en_n(cnt_en_n),
        .dir_down(dir_down), .preset_val(dlo_d), .count(dq_lo),
        .term_flag(d_mm_lo), .chain_n(d_rco_lo));
    updn_cascade_cnt #(.W(4), .MODE(updn_pkg::CNT_DECADE)) i_updn_cascade_cnt_dh (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .cnt_en_n(d_en_hi),
        .dir_down(dir_down), .preset_val(dhi_d), .count(dq_hi),
        .term_flag(d_mm_hi), .chain_n(d_rco_hi));

    function automatic int nxt_b(input int v, input bit dn);
        return dn ? (v + 255) % 256 : (v + 1) % 256;
    endfunction

    function automatic int nxt_d(input int v, input bit dn);
        return dn ? (v + 99) % 100 : (v + 1) % 100;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_counts(input string tag);
        check({bq_hi, bq_lo} == exp_b, {tag, " bin"}, {bq_hi, bq_lo}, exp_b);
        check(dq_hi * 10 + dq_lo == exp_d, {tag, " dec"}, dq_hi * 10 + dq_lo, exp_d);
    endtask

    // Called just after a rising edge; ends just after the next one.
    task automatic do_cycle(input bit e_n, input bit dn);
        int blo, dlo;
        bit mb, md;
        cnt_en_n = e_n;
        dir_down = dn;
        @(negedge clk); #1;
        blo = exp_b % 16;
        dlo = exp_d % 10;
        mb  = dn ? (blo == 0) : (blo == 15);
        md  = dn ? (dlo == 0) : (dlo == 9);
        check(b_mm_lo == mb, "R6 bin flag", b_mm_lo, mb);
        check(d_mm_lo == md, "R6 dec flag", d_mm_lo, md);
        check(b_rco_lo == !(!e_n && mb), "R7 bin chain", b_rco_lo, !(!e_n && mb));
        check(d_rco_lo == !(!e_n && md), "R7 dec chain", d_rco_lo, !(!e_n && md));
        @(posedge clk);
        if (!e_n) begin
            exp_b = nxt_b(exp_b, dn);
            exp_d = nxt_d(exp_d, dn);
        end
        #1;
        check_counts(e_n ? "R4 hold" : (dn ? "R3 R9 down" : "R2 R9 up"));
    endtask

    // Preset held across one enabled edge; checked before and after it.
    task automatic do_preset(input int vb, input int vd);
        bdata    = vb[7:0];
        dlo_d    = 4'(vd % 10);
        dhi_d    = 4'(vd / 10);
        cnt_en_n = 1'b0;
        preset_n = 1'b0;
        exp_b    = vb;
        exp_d    = vd;
        #1;
        check_counts("R5 preset immediate");
        @(posedge clk); #1;
        check_counts("R5 preset over count");
        preset_n = 1'b1;
    endtask

    // Decade low digit forced to an illegal value, then one enabled step.
    task automatic do_illegal(input int lo_val, input bit dn);
        int exp_lo;
        bdata    = 8'h3C;
        dlo_d    = 4'(lo_val);
        dhi_d    = 4'd3;
        dir_down = dn;
        cnt_en_n = 1'b1;
        preset_n = 1'b0;
        @(posedge clk); #1;
        preset_n = 1'b1;
        cnt_en_n = 1'b0;
        @(negedge clk); #1;
        check(d_mm_lo == 1'b0, "R8 illegal flag", d_mm_lo, 0);
        check(d_rco_lo == 1'b1, "R8 illegal chain", d_rco_lo, 1);
        @(posedge clk); #1;
        exp_lo = dn ? 9 : 0;
        check(dq_lo == exp_lo, "R8 illegal recover lo", dq_lo, exp_lo);
        check(dq_hi == 3, "R8 illegal recover hi", dq_hi, 3);
        exp_b = nxt_b(8'h3C, dn);
        check({bq_hi, bq_lo} == exp_b, "R8 bin side", {bq_hi, bq_lo}, exp_b);
        exp_d = 30 + exp_lo;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int r;
        r = $urandom(32'd2718);
        rst_n    = 1'b0;
        preset_n = 1'b1;
        cnt_en_n = 1'b0;
        dir_down = 1'b0;
        bdata    = '0;
        dlo_d    = '0;
        dhi_d    = '0;
        repeat (3) @(posedge clk);
        #1;
        check_counts("R1 reset");
        rst_n = 1'b1;

        // Full up sweep of both pairs, then full down sweep.
        for (int i = 0; i < 256; i++) do_cycle(1'b0, 1'b0);
        for (int i = 0; i < 256; i++) do_cycle(1'b0, 1'b1);

        // Enable held high: nothing moves, flags still decode.
        for (int i = 0; i < 6; i++) do_cycle(1'b1, i[0]);

        // Preset in the middle of counting, then continue both ways.
        for (int i = 0; i < 37; i++) do_cycle(1'b0, 1'b0);
        do_preset(8'hEE, 58);
        for (int i = 0; i < 20; i++) do_cycle(1'b0, 1'b0);
        do_preset(8'h02, 1);
        for (int i = 0; i < 5; i++) do_cycle(1'b0, 1'b1);

        // Wrap points under preset.
        do_preset(8'hFF, 99);
        do_cycle(1'b0, 1'b0);
        do_preset(8'h00, 0);
        do_cycle(1'b0, 1'b1);

        // Illegal decade digits.
        do_illegal(12, 1'b0);
        do_illegal(15, 1'b1);
        do_illegal(10, 1'b1);

        // Reset while enabled.
        rst_n = 1'b0;
        cnt_en_n = 1'b0;
        @(posedge clk); #1;
        exp_b = 0;
        exp_d = 0;
        check_counts("R1 reset mid-run");
        rst_n = 1'b1;

        // Random mix.
        for (int i = 0; i < 800; i++) begin
            r = $urandom;
            if (r % 41 == 0) do_preset(int'(r[15:8]), int'(r[23:16]) % 100);
            else             do_cycle(r % 5 == 0, r[3]);
        end

        finish_run();
    end
endmodule